// File: doc/BRIEF.md
# DRAM Address Interleave Mapper

This block turns a physical byte address into the coordinates a DRAM controller needs: which DIMM slot, which bank on that DIMM, which component bank, and the row and column. The data path is 64 bits wide, so the lowest three address bits only pick byte lanes. Translation starts at bit 3, on the quadword index.

Two mapping schemes are built in, and the block chooses between them at run time from the slot configuration. When both slots are filled with modules of identical geometry, it uses low-order interleaving. The bank-select bits sit just above the column bits, so consecutive pages walk through every bank before any bank repeats. In every other case it uses high-order mapping. DIMM 0 occupies the bottom of the address space and DIMM 1 is stacked directly above it. Inside each DIMM the bank fields are the most significant bits of the DIMM-relative offset. This lets modules of different sizes and types share the system.

Each accepted address produces one registered result, one clock later, with a valid strobe. A flag shows the scheme in use. A second flag marks addresses beyond the installed memory; for those the coordinate outputs keep their previous values.

Top module: `dram_ilv_mapper`

## Requirements
- R1: Address bits [2:0] have no effect on any output; two addresses that differ only there give identical coordinates.
- R2: `out_loi` is 1 exactly when both slots are present and their DIMM-bank, component-bank, size and page fields are all equal; otherwise it is 0.
- R3: In low-order mode the quadword index is split from bit 0 upward into column, component bank, DIMM bank, DIMM select (1 bit), then row.
- R4: With 2 slots × 2 DIMM banks × 2 component banks and 1024-column pages, every aligned 64 KB window of byte addresses hits each of the 8 {dimm, dbank, cbank} combinations exactly once, ordered cbank lowest.
- R5: In high-order mode DIMM 1 starts at the byte address equal to DIMM 0's size (or at 0 when slot 0 is empty). Within a DIMM the offset is split from the top down as DIMM bank, component bank, row, column.
- R6: Field encodings per slot: DIMM-bank bit 0/1 means 1/2 banks; component-bank code 0/1/2/3 means 1/2/4/4 banks; size code s means 4 MB << s; page code p means 256 << min(p,4) columns.
- R7: An address at or above the summed size of the present slots sets `out_oor`, and row, column and bank outputs keep their previous values.
- R8: Results appear one clock after `in_valid`; `out_valid` copies `in_valid` delayed by one cycle, and without `in_valid` all other outputs hold.
- R9: Synchronous active-high reset clears every output to 0.
- R10: An in-range result never selects an absent slot; with only slot 1 present, address 0 maps to DIMM 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Address strobe |
| in_addr | input | ADDR_W | Physical byte address |
| cfg_present | input | 2 | Slot filled, one bit per slot |
| cfg_dbk | input | 2 | DIMM-bank count bit per slot |
| cfg_cbk | input | 4 | Component-bank code, 2 bits per slot |
| cfg_size | input | 6 | Module size code, 3 bits per slot |
| cfg_page | input | 6 | Page size code, 3 bits per slot |
| out_valid | output | 1 | Result strobe |
| out_loi | output | 1 | Low-order mode in use |
| out_oor | output | 1 | Address beyond installed memory |
| out_dimm | output | 1 | DIMM slot select |
| out_dbank | output | 1 | DIMM bank |
| out_cbank | output | 2 | Component bank |
| out_row | output | ROW_W | Row address |
| out_col | output | COL_W | Column address |

## Verification
A wrong mode decision inside the block shows on the very next cycle. `out_loi` flips, and the bank and row fields rearrange, because the low-order path reads the bits just above the column field and the high-order path reads the top of the DIMM offset. A wrong DIMM base or size shows only for addresses near the slot boundary or the top of memory. So the stimulus aims at those edges as well as at random addresses under matched, mismatched and single-slot configurations. A fault in the hold logic shows as coordinates that change on an out-of-range or idle cycle, also within one cycle.

// File: rtl/dim_map_pkg.sv
package dim_map_pkg;

  // Decoded geometry of one slot, all as log2 quantities in quadwords.
  typedef struct packed {
    logic [5:0] col_lg;
    logic [5:0] cbk_lg;
    logic [5:0] dbk_lg;
    logic [5:0] dimm_lg;
  } dim_geom_t;

  // Mask with the lowest n bits set.
  function automatic logic [63:0] lo_mask(input logic [5:0] n);
    return (64'd1 << n) - 64'd1;
  endfunction

endpackage

// File: rtl/dim_cfg_decode.sv
module dim_cfg_decode
  import dim_map_pkg::*;
#(
  parameter int SZ_BASE_LG = 19,
  parameter int PG_BASE_LG = 8,
  parameter int PG_MAX     = 4
) (
  input  logic       dbk,
  input  logic [1:0] cbk,
  input  logic [2:0] size,
  input  logic [2:0] page,
  output dim_geom_t  geom
);

  always_comb begin
    geom.col_lg  = 6'(PG_BASE_LG) + ((page > 3'(PG_MAX)) ? 6'(PG_MAX) : 6'(page));
    geom.cbk_lg  = (cbk == 2'd0) ? 6'd0 : (cbk == 2'd1) ? 6'd1 : 6'd2;
    geom.dbk_lg  = {5'd0, dbk};
    geom.dimm_lg = 6'(SZ_BASE_LG) + 6'(size);
  end

endmodule

// File: rtl/dim_mode_sel.sv
module dim_mode_sel
  import dim_map_pkg::*;
#(
  parameter int QW_W = 27
) (
  input  logic [1:0]  present,
  input  logic [8:0]  raw0,
  input  logic [8:0]  raw1,
  input  dim_geom_t   geom0,
  input  dim_geom_t   geom1,
  output logic        loi,
  output logic [QW_W:0] base1,
  output logic [QW_W:0] total
);

  localparam int TW = QW_W + 1;

  logic [QW_W:0] sz0, sz1;

  always_comb begin
    sz0   = present[0] ? (TW'(1) << geom0.dimm_lg) : '0;
    sz1   = present[1] ? (TW'(1) << geom1.dimm_lg) : '0;
    base1 = sz0;
    total = sz0 + sz1;
    loi   = (present == 2'b11) && (raw0 == raw1);
  end

endmodule

// File: rtl/dim_hoi_xlate.sv
module dim_hoi_xlate
  import dim_map_pkg::*;
#(
  parameter int QW_W  = 27,
  parameter int ROW_W = 18,
  parameter int COL_W = 12
) (
  input  logic [QW_W-1:0]  a3,
  input  logic [1:0]       present,
  input  logic [QW_W:0]    base1,
  input  dim_geom_t        geom0,
  input  dim_geom_t        geom1,
  output logic             dimm,
  output logic             dbank,
  output logic [1:0]       cbank,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col
);

  logic            sel1;
  logic [QW_W-1:0] off;
  logic [5:0]      bank_sh;
  dim_geom_t       g;

  always_comb begin
    sel1    = present[1] && ({1'b0, a3} >= base1);
    off     = a3 - (sel1 ? QW_W'(base1) : '0);
    g       = sel1 ? geom1 : geom0;
    bank_sh = g.dimm_lg - g.dbk_lg - g.cbk_lg;
    dimm    = sel1;
    cbank   = 2'((off >> bank_sh) & QW_W'(lo_mask(g.cbk_lg)));
    dbank   = 1'((off >> (bank_sh + g.cbk_lg)) & QW_W'(lo_mask(g.dbk_lg)));
    row     = ROW_W'((off >> g.col_lg) & QW_W'(lo_mask(bank_sh - g.col_lg)));
    col     = COL_W'(off & QW_W'(lo_mask(g.col_lg)));
  end

endmodule

// File: rtl/dim_loi_xlate.sv
module dim_loi_xlate
  import dim_map_pkg::*;
#(
  parameter int QW_W  = 27,
  parameter int ROW_W = 18,
  parameter int COL_W = 12
) (
  input  logic [QW_W-1:0]  a3,
  input  dim_geom_t        g,
  output logic             dimm,
  output logic             dbank,
  output logic [1:0]       cbank,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col
);

  logic [QW_W-1:0] t1, t2, t3;

  always_comb begin
    t1    = a3 >> g.col_lg;
    t2    = t1 >> g.cbk_lg;
    t3    = t2 >> g.dbk_lg;
    col   = COL_W'(a3 & QW_W'(lo_mask(g.col_lg)));
    cbank = 2'(t1 & QW_W'(lo_mask(g.cbk_lg)));
    dbank = 1'(t2 & QW_W'(lo_mask(g.dbk_lg)));
    dimm  = t3[0];
    row   = ROW_W'(t3 >> 1);
  end

endmodule

// File: rtl/dram_ilv_mapper.sv
module dram_ilv_mapper
  import dim_map_pkg::*;
#(
  parameter int ADDR_W     = 30,
  parameter int ROW_W      = 18,
  parameter int COL_W      = 12,
  parameter int SZ_BASE_LG = 19,
  parameter int PG_BASE_LG = 8,
  parameter int PG_MAX     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        cfg_present,
  input  logic [1:0]        cfg_dbk,
  input  logic [3:0]        cfg_cbk,
  input  logic [5:0]        cfg_size,
  input  logic [5:0]        cfg_page,
  output logic              out_valid,
  output logic              out_loi,
  output logic              out_oor,
  output logic              out_dimm,
  output logic              out_dbank,
  output logic [1:0]        out_cbank,
  output logic [ROW_W-1:0]  out_row,
  output logic [COL_W-1:0]  out_col
);

  localparam int QW_W  = ADDR_W - 3;
  localparam int NSLOT = 2;

  dim_geom_t       geom [NSLOT];
  logic [8:0]      raw  [NSLOT];
  logic            loi;
  logic [QW_W:0]   base1, total;
  logic [QW_W-1:0] a3;
  logic            in_range;

  logic             h_dimm, h_dbank, l_dimm, l_dbank;
  logic [1:0]       h_cbank, l_cbank;
  logic [ROW_W-1:0] h_row, l_row;
  logic [COL_W-1:0] h_col, l_col;

  // Byte-lane bits never enter the translation.
  assign a3       = in_addr[ADDR_W-1:3];
  assign in_range = ({1'b0, a3} < total);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign raw[s] = {cfg_dbk[s], cfg_cbk[2*s +: 2], cfg_size[3*s +: 3], cfg_page[3*s +: 3]};
    dim_cfg_decode #(
      .SZ_BASE_LG(SZ_BASE_LG), .PG_BASE_LG(PG_BASE_LG), .PG_MAX(PG_MAX)
    ) u_dec (
      .dbk (cfg_dbk[s]),
      .cbk (cfg_cbk[2*s +: 2]),
      .size(cfg_size[3*s +: 3]),
      .page(cfg_page[3*s +: 3]),
      .geom(geom[s])
    );
  end

  dim_mode_sel #(.QW_W(QW_W)) u_mode (
    .present(cfg_present), .raw0(raw[0]), .raw1(raw[1]),
    .geom0(geom[0]), .geom1(geom[1]),
    .loi(loi), .base1(base1), .total(total)
  );

  dim_hoi_xlate #(.QW_W(QW_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_hoi (
    .a3(a3), .present(cfg_present), .base1(base1),
    .geom0(geom[0]), .geom1(geom[1]),
    .dimm(h_dimm), .dbank(h_dbank), .cbank(h_cbank), .row(h_row), .col(h_col)
  );

  dim_loi_xlate #(.QW_W(QW_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_loi (
    .a3(a3), .g(geom[0]),
    .dimm(l_dimm), .dbank(l_dbank), .cbank(l_cbank), .row(l_row), .col(l_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_loi   <= 1'b0;
      out_oor   <= 1'b0;
      out_dimm  <= 1'b0;
      out_dbank <= 1'b0;
      out_cbank <= '0;
      out_row   <= '0;
      out_col   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_loi <= loi;
        out_oor <= !in_range;
        if (in_range) begin
          out_dimm  <= loi ? l_dimm  : h_dimm;
          out_dbank <= loi ? l_dbank : h_dbank;
          out_cbank <= loi ? l_cbank : h_cbank;
          out_row   <= loi ? l_row   : h_row;
          out_col   <= loi ? l_col   : h_col;
        end
      end
    end
  end

  // R8: strobe travels with a single register stage.
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r8_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R8: an idle cycle leaves the coordinates alone.
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_row) && $stable(out_col) && $stable(out_cbank)));
  // R7: out-of-range result keeps the previous coordinates.
  a_r7_oor_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_oor) |-> ($stable(out_row) && $stable(out_col) &&
                                $stable(out_dimm) && $stable(out_dbank) && $stable(out_cbank)));
  // R2: low-order mode only with both slots filled.
  a_r2_loi_pair: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_loi) |-> ($past(cfg_present) == 2'b11));
  // R10: an in-range result lands in a present slot.
  a_r10_present_slot: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_oor) |-> (out_dimm ? $past(cfg_present[1]) : $past(cfg_present[0])));

endmodule

// File: tb/tb_dram_ilv_mapper.sv
module tb_dram_ilv_mapper;
  localparam int ADDR_W = 30;
  localparam int ROW_W  = 18;
  localparam int COL_W  = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [ADDR_W-1:0] in_addr  = '0;
  logic [1:0] cfg_present = 2'b00, cfg_dbk = 2'b00;
  logic [3:0] cfg_cbk = '0;
  logic [5:0] cfg_size = '0, cfg_page = '0;
  logic out_valid, out_loi, out_oor, out_dimm, out_dbank;
  logic [1:0] out_cbank;
  logic [ROW_W-1:0] out_row;
  logic [COL_W-1:0] out_col;

  dram_ilv_mapper dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
    .cfg_present(cfg_present), .cfg_dbk(cfg_dbk), .cfg_cbk(cfg_cbk),
    .cfg_size(cfg_size), .cfg_page(cfg_page),
    .out_valid(out_valid), .out_loi(out_loi), .out_oor(out_oor),
    .out_dimm(out_dimm), .out_dbank(out_dbank), .out_cbank(out_cbank),
    .out_row(out_row), .out_col(out_col)
  );

  always #2 clk = ~clk;

  typedef struct {
    bit oor; bit loi;
    longint dimm, dbank, cbank, row, col;
  } exp_t;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  exp_t prev = '{default: 0};

  task automatic cmp(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  function automatic longint slot_qw(int s);
    return longint'(524288) << cfg_size[3*s +: 3];
  endfunction

  function automatic exp_t model(longint a);
    exp_t e;
    longint q[2], base1, total, a3, off, t, ndb, ncb, ncol, dbsz, cbsz;
    int pg, cb, s;
    for (int k = 0; k < 2; k++) q[k] = cfg_present[k] ? slot_qw(k) : 0;
    base1 = q[0];
    total = q[0] + q[1];
    a3 = a >> 3;
    e = prev;
    e.loi = (cfg_present == 2'b11) && (cfg_dbk[0] == cfg_dbk[1]) &&
            (cfg_cbk[1:0] == cfg_cbk[3:2]) && (cfg_size[2:0] == cfg_size[5:3]) &&
            (cfg_page[2:0] == cfg_page[5:3]);
    e.oor = (a3 >= total);
    if (e.oor) return e;
    s = e.loi ? 0 : ((cfg_present[1] && a3 >= base1) ? 1 : 0);
    ndb = cfg_dbk[s] ? 2 : 1;
    cb  = int'(cfg_cbk[2*s +: 2]);
    ncb = (cb == 0) ? 1 : (cb == 1) ? 2 : 4;
    pg  = int'(cfg_page[3*s +: 3]);
    ncol = longint'(256) << ((pg > 4) ? 4 : pg);
    if (e.loi) begin
      e.col = a3 % ncol;   t = a3 / ncol;
      e.cbank = t % ncb;   t = t / ncb;
      e.dbank = t % ndb;   t = t / ndb;
      e.dimm = t % 2;      e.row = t / 2;
    end else begin
      off = a3 - ((s == 1) ? base1 : 0);
      e.dimm = s;
      dbsz = slot_qw(s) / ndb;
      e.dbank = off / dbsz;  off = off % dbsz;
      cbsz = dbsz / ncb;
      e.cbank = off / cbsz;  off = off % cbsz;
      e.row = off / ncol;    e.col = off % ncol;
    end
    return e;
  endfunction

  task automatic xact(longint a, string tag);
    exp_t e;
    in_valid = 1'b1;
    in_addr  = a[ADDR_W-1:0];
    e = model(a);
    @(negedge clk);
    in_valid = 1'b0;
    cmp("R8", "valid", out_valid, 1);
    cmp("R2", "loi", out_loi, e.loi);
    cmp(e.oor ? "R7" : tag, "oor", out_oor, e.oor);
    cmp(tag, "dimm", out_dimm, e.dimm);
    cmp(tag, "dbank", out_dbank, e.dbank);
    cmp(tag, "cbank", out_cbank, e.cbank);
    cmp(tag, "row", out_row, e.row);
    cmp(tag, "col", out_col, e.col);
    prev = e;
  endtask

  task automatic set_slot(int s, bit db, int cb, int sz, int pg);
    cfg_dbk[s] = db;
    cfg_cbk[2*s +: 2] = 2'(cb);
    cfg_size[3*s +: 3] = 3'(sz);
    cfg_page[3*s +: 3] = 3'(pg);
  endtask

  task automatic rand_slot(int s);
    set_slot(s, 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
             int'($urandom_range(0, 7)), int'($urandom_range(0, 7)));
  endtask

  task automatic rand_addrs(int n, string tag);
    longint tb, hi, a;
    tb = ((cfg_present[0] ? slot_qw(0) : 0) + (cfg_present[1] ? slot_qw(1) : 0)) * 8;
    hi = tb + tb / 8;
    if (hi > (longint'(1) << ADDR_W) - 1) hi = (longint'(1) << ADDR_W) - 1;
    for (int i = 0; i < n; i++) begin
      a = {$urandom, $urandom} % (hi + 1);
      if (a < 0) a = -a;
      xact(a, tag);
    end
    if (tb <= hi) xact(tb, "R7");
    if (tb > 0) xact(tb - 8, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R8 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    longint idx;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9: reset state
    cmp("R9", "valid", out_valid, 0); cmp("R9", "loi", out_loi, 0);
    cmp("R9", "oor", out_oor, 0);     cmp("R9", "row", out_row, 0);
    cmp("R9", "col", out_col, 0);     cmp("R9", "cbank", out_cbank, 0);
    rst = 1'b0;

    // R4: matched pair, 8 banks, 1024 columns, 64 KB window
    cfg_present = 2'b11; set_slot(0, 1, 1, 1, 2); set_slot(1, 1, 1, 1, 2);
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      xact(longint'(32'h0003_0000) + k * 8192 + 40, "R3");
      idx = out_dimm * 4 + out_dbank * 2 + out_cbank;
      cmp("R4", "bank index", idx, k);
    end

    // R1: byte-lane bits ignored
    xact(longint'(32'h0012_3450), "R1");
    xact(longint'(32'h0012_3457), "R1");
    cmp("R1", "col", out_col, (32'h0012_3450 >> 3) % 1024);

    // R8: idle cycle holds outputs
    in_addr = 30'h0ABC_DEF8;
    @(negedge clk);
    cmp("R8", "idle valid", out_valid, 0);
    cmp("R8", "idle col", out_col, prev.col);
    cmp("R8", "idle row", out_row, prev.row);

    // R5: mismatched sizes, DIMM 1 starts at 8 MB
    set_slot(0, 0, 0, 1, 0); set_slot(1, 0, 0, 2, 0);
    @(negedge clk);
    xact(longint'(8) << 20, "R5");
    cmp("R5", "dimm at 8MB", out_dimm, 1); cmp("R5", "row at 8MB", out_row, 0);
    cmp("R2", "loi mismatch", out_loi, 0);
    xact((longint'(8) << 20) - 8, "R5");
    cmp("R5", "dimm below 8MB", out_dimm, 0);

    // R7: first address past 8 MB + 16 MB
    xact(longint'(24) << 20, "R7");
    cmp("R7", "oor flag", out_oor, 1);

    // R10: only slot 1 present
    cfg_present = 2'b10;
    @(negedge clk);
    xact(0, "R10");
    cmp("R10", "dimm", out_dimm, 1);

    // R6: page code clamps to 4096 columns, cbank code 3 means 4 banks
    cfg_present = 2'b01; set_slot(0, 0, 3, 0, 7);
    @(negedge clk);
    xact(4096 * 8, "R6");
    cmp("R6", "row", out_row, 1); cmp("R6", "col", out_col, 0);
    xact((longint'(1) << 17) * 8, "R6");
    cmp("R6", "cbank", out_cbank, 1);

    // Random: matched pairs, mismatched pairs, single slots
    for (int c = 0; c < 12; c++) begin
      cfg_present = 2'b11; rand_slot(0);
      cfg_dbk[1] = cfg_dbk[0]; cfg_cbk[3:2] = cfg_cbk[1:0];
      cfg_size[5:3] = cfg_size[2:0]; cfg_page[5:3] = cfg_page[2:0];
      @(negedge clk);
      rand_addrs(40, "R3");
    end
    for (int c = 0; c < 12; c++) begin
      cfg_present = 2'b11; rand_slot(0); rand_slot(1);
      if (cfg_size[5:3] == cfg_size[2:0]) cfg_size[5:3] = cfg_size[2:0] + 3'd1;
      @(negedge clk);
      rand_addrs(40, "R5");
    end
    for (int c = 0; c < 12; c++) begin
      cfg_present = (c % 2 == 0) ? 2'b01 : 2'b10; rand_slot(0); rand_slot(1);
      @(negedge clk);
      rand_addrs(40, "R10");
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule